// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Peripheral Takeover

This block drives seven pads. Software reaches four byte-wide registers over a simple single-cycle bus. One register holds the output levels. One sets each pin's direction. One selects reduced drive strength per pin. The last is a read-only view of the real pad levels. Each pin has an output-enable, an output value and a low-drive select that go straight to the pad cell. Pad inputs pass through a two-flop synchronizer before any read path sees them.

When the peripheral-enable input is high, an attached peripheral takes over direction and output level on all seven pins. The direction register keeps its contents but no longer steers the pads. The status register always shows the synchronized pad level, including on pins that are driving. Software can therefore compare the level it commanded with the level the pad reached and detect a shorted or overloaded output.

The bus has no back-pressure. Every selected access finishes in the cycle it is presented. A write takes effect at that clock edge. Read data is a combinational function of address and state in the same cycle, and it is zero whenever no read is selected.

Top module: `gpio_port`

## Requirements
- R1: Only bits 6..0 are implemented. In every register, bit 7 reads as 0, and writing 1 to bit 7 changes nothing.
- R2: Reset clears the direction, drive and output latch bits. After reset, pad_oe, pad_out and pad_lowdrv are all 0, and reads of every register return 0 while the pads are low.
- R3: The direction register at offset 0x1A is readable and writable. With peripheral_en low, bit n of this register (1 = output, 0 = input) appears on pad_oe[n].
- R4: The drive register at offset 0x1B is readable and writable. pad_lowdrv[n] is 1 only when drive bit n is 1 and pin n is currently driving (pad_oe[n] = 1). A 1 selects about one-third drive strength.
- R5: The status register at offset 0x19 returns the synchronized level of every pad, including pads configured as outputs. Writes to it have no effect.
- R6: A pad level change is visible in status and data reads after exactly two rising clock edges. It is not visible after one.
- R7: A read of the data register at offset 0x18 returns the latch bit for pins whose direction bit is 1, and the synchronized pad level for pins whose direction bit is 0.
- R8: A write to offset 0x18 loads the output latch whatever the direction bits hold. With peripheral_en low, pad_out equals the latch.
- R9: While peripheral_en is 1, pad_oe follows periph_oe and pad_out follows periph_dout. The direction register keeps its value and still reads back.
- R10: Reads of unmapped offsets return 0, and writes to them change no register. rdata is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| periph_en | input | 1 | Peripheral takes over all pins |
| periph_oe | input | 7 | Peripheral output enables |
| periph_dout | input | 7 | Peripheral output levels |
| pad_in | input | 7 | Raw pad levels (asynchronous) |
| pad_oe | output | 7 | Pad output enable |
| pad_out | output | 7 | Pad output level |
| pad_lowdrv | output | 7 | Pad reduced-drive select |

## Verification
Some properties are checked on every cycle by assertions. These are the two-edge synchronizer delay, the latch capture on data writes, the direction and drive registers holding when not written, low drive never asserted on a non-driving pin, and the peripheral override. Other behaviours need a model of the pad and can only be shown by bench scenarios. These include the mixed latch/pad readback of the data register across every direction pattern, short detection through the status register, and bit 7 and unmapped-offset handling. Exactly when a pad change first becomes readable is also checked only by the bench.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_PINS = 7;
  localparam int BUS_AW    = 8;
  localparam int BUS_DW    = 8;

  typedef enum logic [BUS_AW-1:0] {
    OFS_DATA = 8'h18,
    OFS_STAT = 8'h19,
    OFS_DIR  = 8'h1A,
    OFS_DRV  = 8'h1B
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  // cycles since reset, saturating at 2, so the check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assert_sync_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_out == $past(raw_in, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int PINS = PORT_PINS,
  parameter int AW   = BUS_AW,
  parameter int DW   = BUS_DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [PINS-1:0] sync_lvl,
  output logic [DW-1:0]   rdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] drv_q,
  output logic [PINS-1:0] latch_q
);
  localparam int PAD = DW - PINS;

  logic wr_data, wr_dir, wr_drv, rd;
  assign wr_data = sel && we && (addr == OFS_DATA);
  assign wr_dir  = sel && we && (addr == OFS_DIR);
  assign wr_drv  = sel && we && (addr == OFS_DRV);
  assign rd      = sel && !we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      drv_q   <= '0;
      latch_q <= '0;
    end else begin
      if (wr_data) latch_q <= wdata[PINS-1:0];
      if (wr_dir)  dir_q   <= wdata[PINS-1:0];
      if (wr_drv)  drv_q   <= wdata[PINS-1:0];
    end
  end

  logic [PINS-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (rd) begin
      case (addr)
        OFS_DATA: rd_val = (latch_q & dir_q) | (sync_lvl & ~dir_q);
        OFS_STAT: rd_val = sync_lvl;
        OFS_DIR:  rd_val = dir_q;
        OFS_DRV:  rd_val = drv_q;
        default:  rd_val = '0;
      endcase
    end
  end

  assign rdata = {{PAD{1'b0}}, rd_val};

  assert_latch_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (latch_q == $past(wdata[PINS-1:0])));
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  assert_drv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_drv |=> $stable(drv_q));
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
  parameter int PINS = 7
) (
  input  logic            periph_en,
  input  logic [PINS-1:0] periph_oe,
  input  logic [PINS-1:0] periph_dout,
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] latch,
  input  logic [PINS-1:0] drv,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_lowdrv
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic oe_i;
    assign oe_i          = periph_en ? periph_oe[i]   : dir[i];
    assign pad_oe[i]     = oe_i;
    assign pad_out[i]    = periph_en ? periph_dout[i] : latch[i];
    assign pad_lowdrv[i] = drv[i] & oe_i;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PINS = PORT_PINS,
  parameter int AW   = BUS_AW,
  parameter int DW   = BUS_DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            periph_en,
  input  logic [PINS-1:0] periph_oe,
  input  logic [PINS-1:0] periph_dout,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_lowdrv
);
  logic [PINS-1:0] sync_lvl, dir_q, drv_q, latch_q;

  gpio_sync #(.WIDTH(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(sync_lvl)
  );

  gpio_regs #(.PINS(PINS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .sync_lvl(sync_lvl), .rdata(bus_rdata),
    .dir_q(dir_q), .drv_q(drv_q), .latch_q(latch_q)
  );

  gpio_padmux #(.PINS(PINS)) u_padmux (
    .periph_en(periph_en), .periph_oe(periph_oe), .periph_dout(periph_dout),
    .dir(dir_q), .latch(latch_q), .drv(drv_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_lowdrv(pad_lowdrv)
  );

  assert_lowdrv_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_lowdrv & ~pad_oe) == '0));
  assert_periph_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en |-> (pad_oe == periph_oe && pad_out == periph_dout));
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       periph_en = 1'b0;
  logic [6:0] periph_oe = '0, periph_dout = '0;
  logic [6:0] pad_in, pad_oe, pad_out, pad_lowdrv;
  logic [6:0] ext = '0, short_en = '0, short_val = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  // pad model: a short wins, then own drive, then the external source
  assign pad_in = (short_en & short_val) |
                  (~short_en & ((pad_oe & pad_out) | (~pad_oe & ext)));

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_en(periph_en), .periph_oe(periph_oe), .periph_dout(periph_dout),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_lowdrv(pad_lowdrv)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [6:0] latch_pat, exp7;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 pad_oe", {1'b0, pad_oe}, 8'h00);
    chk("R2 pad_out", {1'b0, pad_out}, 8'h00);
    chk("R2 pad_lowdrv", {1'b0, pad_lowdrv}, 8'h00);
    rst_n = 1'b1;
    settle();
    rd(8'h1A, v); chk("R2 dir reset", v, 8'h00);
    rd(8'h1B, v); chk("R2 drv reset", v, 8'h00);
    rd(8'h18, v); chk("R2 data reset", v, 8'h00);
    chk("R10 idle rdata", bus_rdata, 8'h00);

    // R1: bit 7 unimplemented
    wr(8'h1A, 8'hFF); rd(8'h1A, v); chk("R1 dir bit7", v, 8'h7F);
    wr(8'h1B, 8'h80); rd(8'h1B, v); chk("R1 drv bit7", v, 8'h00);
    wr(8'h1A, 8'h00);

    // R6: two-edge readback latency on inputs
    ext = 7'h15; settle();
    @(negedge clk); ext = 7'h6A;
    rd(8'h19, v); chk("R6 after one edge", v, 8'h15);
    rd(8'h19, v); chk("R6 after two edges", v, 8'h6A);
    rd(8'h18, v); chk("R6 data input path", v, 8'h6A);

    // R3 R4 R7 R8: sweep all direction patterns
    latch_pat = 7'h2B; ext = 7'h56;
    wr(8'h18, {1'b0, latch_pat});
    wr(8'h1B, 8'h7F);
    for (int d = 0; d < 128; d++) begin
      wr(8'h1A, 8'(d));
      chk("R3 pad_oe", {1'b0, pad_oe}, 8'(d));
      chk("R8 pad_out", {1'b0, pad_out}, {1'b0, latch_pat});
      chk("R4 lowdrv gated", {1'b0, pad_lowdrv}, 8'(d));
      settle();
      exp7 = (latch_pat & 7'(d)) | (ext & ~7'(d));
      rd(8'h18, v); chk("R7 data mix", v, {1'b0, exp7});
      rd(8'h19, v); chk("R5 status", v, {1'b0, exp7});
    end

    // R4: sweep drive patterns against a fixed direction
    wr(8'h1A, 8'h0F);
    for (int s = 0; s < 128; s++) begin
      wr(8'h1B, 8'(s));
      chk("R4 lowdrv", {1'b0, pad_lowdrv}, 8'(s & 8'h0F));
      rd(8'h1B, v); chk("R4 drv readback", v, 8'(s));
    end

    // R8: latch loads while pins are inputs
    wr(8'h1A, 8'h00);
    wr(8'h18, 8'h33);
    chk("R8 pad_oe stays 0", {1'b0, pad_oe}, 8'h00);
    wr(8'h1A, 8'h7F);
    chk("R8 latch ready on enable", {1'b0, pad_out}, 8'h33);

    // R5: short detection and read-only status
    wr(8'h18, 8'h55);
    short_en = 7'h02; short_val = 7'h02; settle();
    rd(8'h19, v); chk("R5 short seen", v, 8'h57);
    rd(8'h18, v); chk("R7 data shows latch", v, 8'h55);
    wr(8'h19, 8'h00); settle();
    rd(8'h19, v); chk("R5 write ignored", v, 8'h57);
    short_en = '0;

    // R9: peripheral override
    wr(8'h1A, 8'h00); wr(8'h1B, 8'h7F);
    periph_oe = 7'h3C; periph_dout = 7'h14; periph_en = 1'b1;
    @(negedge clk);
    chk("R9 pad_oe", {1'b0, pad_oe}, 8'h3C);
    chk("R9 pad_out", {1'b0, pad_out}, 8'h14);
    chk("R9 R4 lowdrv", {1'b0, pad_lowdrv}, 8'h3C);
    wr(8'h1A, 8'h41);
    chk("R9 dir ignored", {1'b0, pad_oe}, 8'h3C);
    rd(8'h1A, v); chk("R9 dir readback", v, 8'h41);
    periph_en = 1'b0;
    @(negedge clk);
    chk("R9 release", {1'b0, pad_oe}, 8'h41);

    // R10: unmapped offsets
    wr(8'h1C, 8'hFF); wr(8'h00, 8'hFF);
    rd(8'h1C, v); chk("R10 unmapped read", v, 8'h00);
    rd(8'h17, v); chk("R10 unmapped read low", v, 8'h00);
    rd(8'h1A, v); chk("R10 dir untouched", v, 8'h41);
    rd(8'h1B, v); chk("R10 drv untouched", v, 8'h7F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule